// File: doc/BRIEF.md
# Conversion Result Averager

This block sits on the result path of an analog-to-digital converter, between the 10-bit conversion stream and the per-sequence result queues. Each incoming result carries a 3-bit step tag naming the sequence step that produced it. In its default state the block forwards every result untouched. When an averaging factor is programmed, the block sums a power-of-two number of consecutive results and sends a single entry, the truncated mean, downstream. The output rate therefore falls by the same factor. Every channel uses the same factor, whether it is single-ended or differential.

The conversion engine is expected to repeat a step N times when averaging is on. The averager sends one entry when the Nth result of the group arrives and then starts a new group. A new averaging setting is picked up only when a group starts, so a group that is under way always finishes with the factor it began with.

Both data interfaces are valid/ready. A result is taken on a rising clock edge when `in_valid` and `in_ready` are both high. An entry leaves when `out_valid` and `out_ready` are both high. The block has one output register. While that register holds an entry the sink has not accepted, `in_ready` drops, because the next result could complete a group. `in_ready` is high whenever the register is empty or is being emptied in the same cycle. `out_valid` stays high, and `out_data` and `out_step` hold their values, until the entry is taken.

Top module: `adc_avg_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With `avg_sel` = 0 (bypass), each accepted result appears one cycle later on `out_data` with the same value and tag. There is exactly one output entry per accepted result.
- R3: With `avg_sel` = f, where f is 1 to 6, one entry is emitted for every 2^f accepted results. Its value is floor(sum of the group / 2^f).
- R4: `avg_sel` = 7 behaves the same as 6, so groups are 64 results long.
- R5: A change of `avg_sel` while a group is partly collected has no effect on that group. The new value applies from the first result of the next group.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with `out_data` and `out_step` unchanged, and `in_ready` is 0. Otherwise `in_ready` is 1.
- R7: The emitted `out_step` is the tag of the result that completes the group.
- R8: A group of 64 full-scale results (0x3FF) produces 0x3FF. The running sum never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| avg_sel | input | 3 | Averaging select: 0 bypass, f gives 2^f results, 7 saturates at 64 |
| in_valid | input | 1 | A conversion result is offered |
| in_ready | output | 1 | The block can take a result this cycle |
| in_data | input | 10 | Unsigned conversion result |
| in_step | input | 3 | Sequence step tag of the result |
| out_valid | output | 1 | An averaged or forwarded entry is available |
| out_ready | input | 1 | The sink takes the entry this cycle |
| out_data | output | 10 | Entry value |
| out_step | output | 3 | Step tag of the entry |

## Verification
The averager is first run in bypass and at every factor from 2 to 64 on random results. This separates a wrong group length from a wrong shift amount. Factor field 7 is driven separately to show that it saturates, and not that it wraps or becomes bypass. Full-scale and all-zero groups probe the top and bottom of the sum. Random factor changes inside groups show whether the factor is latched per group, and a randomly stalled sink shows whether data is lost or changes while the output is held.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
  localparam int DATA_W  = 10;
  localparam int STEP_W  = 3;
  localparam int SEL_W   = 3;
  localparam int MAX_LOG = 6;
  localparam int CNT_W   = MAX_LOG;
  localparam int ACC_W   = DATA_W + MAX_LOG;
  localparam int SH_W    = 3;

  // Map the control field to a shift amount, saturating at MAX_LOG.
  function automatic logic [SH_W-1:0] sel_to_shift(input logic [SEL_W-1:0] sel);
    if (int'(sel) > MAX_LOG) return SH_W'(MAX_LOG);
    return SH_W'(sel);
  endfunction
endpackage

// File: rtl/adc_avg_ctrl.sv
module adc_avg_ctrl
  import adc_avg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  avg_sel,
  input  logic              accept,
  output logic [SH_W-1:0]   eff_shift,
  output logic              last,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [SH_W-1:0]   act_q
);
  localparam int LIM_W = CNT_W + 1;

  logic [LIM_W-1:0] grp_len;

  // A new factor is adopted only when no group is in progress.
  assign eff_shift = (cnt_q == '0) ? sel_to_shift(avg_sel) : act_q;
  assign grp_len   = {{CNT_W{1'b0}}, 1'b1} << eff_shift;
  assign last      = ({1'b0, cnt_q} == (grp_len - LIM_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (accept) begin
      if (cnt_q == '0) act_q <= eff_shift;
      cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/adc_avg_accum.sv
module adc_avg_accum
  import adc_avg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              last,
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   eff_shift,
  output logic [DATA_W-1:0] avg
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_next;
  logic [ACC_W-1:0] scaled;

  assign sum_next = acc_q + ACC_W'(din);
  assign scaled   = sum_next >> eff_shift;
  assign avg      = scaled[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (accept) acc_q <= last ? '0 : sum_next;
  end
endmodule

// File: rtl/adc_avg_outreg.sv
module adc_avg_outreg
  import adc_avg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [STEP_W-1:0] ld_step,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [STEP_W-1:0] out_step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_step  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_step  <= ld_step;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_avg_unit.sv
module adc_avg_unit
  import adc_avg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  avg_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [STEP_W-1:0] in_step,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [STEP_W-1:0] out_step
);
  logic              accept;
  logic              last;
  logic [SH_W-1:0]   eff_shift;
  logic [CNT_W-1:0]  grp_cnt;
  logic [SH_W-1:0]   grp_shift;
  logic [DATA_W-1:0] avg;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  adc_avg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .avg_sel(avg_sel), .accept(accept),
    .eff_shift(eff_shift), .last(last), .cnt_q(grp_cnt), .act_q(grp_shift)
  );

  adc_avg_accum u_accum (
    .clk(clk), .rst_n(rst_n), .accept(accept), .last(last),
    .din(in_data), .eff_shift(eff_shift), .avg(avg)
  );

  adc_avg_outreg u_out (
    .clk(clk), .rst_n(rst_n), .load(accept && last), .ld_data(avg),
    .ld_step(in_step), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_step(out_step)
  );
endmodule

// File: rtl/adc_avg_chk.sv
module adc_avg_chk
  import adc_avg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  avg_sel,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [STEP_W-1:0] in_step,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [STEP_W-1:0] out_step,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [SH_W-1:0]   act_q
);
  logic [CNT_W:0] act_len;
  assign act_len = {{CNT_W{1'b0}}, 1'b1} << act_q;

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_step));

  a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && cnt_q == '0 && avg_sel == '0
    |=> out_valid && out_data == $past(in_data) && out_step == $past(in_step));

  a_r5_factor_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0 |=> act_q == $past(act_q));

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0 |-> {1'b0, cnt_q} < act_len);

  a_r4_shift_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_q) <= MAX_LOG);
endmodule

bind adc_avg_unit adc_avg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .avg_sel(avg_sel), .in_valid(in_valid),
  .in_ready(in_ready), .in_data(in_data), .in_step(in_step),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_step(out_step), .cnt_q(grp_cnt), .act_q(grp_shift)
);

// File: tb/adc_avg_unit_bench.sv
module adc_avg_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] avg_sel = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_data = '0;
  logic [2:0] in_step = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_data;
  logic [2:0] out_step;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  int m_cnt = 0, m_sum = 0, m_shift = 0;
  logic [12:0] exp_q[$];
  bit hold_pend = 1'b0;
  logic [12:0] hold_v;
  bit acc_flag;
  int seed_dummy;

  always #10 clk = ~clk;

  adc_avg_unit u_adc_avg_unit (
    .clk(clk), .rst_n(rst_n), .avg_sel(avg_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_step(in_step),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_step(out_step)
  );

  function automatic int sat_sel(input logic [2:0] s);
    return (s > 3'd6) ? 6 : int'(s);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Entered just after a falling edge; evaluates handshakes of the coming edge.
  task automatic tick(input string req, input bit rdy_rand);
    out_ready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
    #1;
    if (hold_pend)
      check({out_valid, out_step, out_data} == {1'b1, hold_v}, "R6 hold",
            int'({out_valid, out_step, out_data}), int'({1'b1, hold_v}));
    hold_pend = out_valid && !out_ready;
    if (hold_pend) begin
      hold_v = {out_step, out_data};
      check(in_ready == 1'b0, "R6 stall", int'(in_ready), 0);
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, {req, " spurious"}, int'(out_data), -1);
      else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        check({out_step, out_data} == e, req, int'({out_step, out_data}), int'(e));
      end
    end
    acc_flag = 1'b0;
    if (in_valid && in_ready) begin
      acc_flag = 1'b1;
      if (m_cnt == 0) m_shift = sat_sel(avg_sel);
      m_sum += int'(in_data);
      m_cnt++;
      if (m_cnt == (1 << m_shift)) begin
        exp_q.push_back({in_step, 10'(m_sum >> m_shift)});
        m_cnt = 0;
        m_sum = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [9:0] d, input logic [2:0] st, input string req,
                      input bit rdy_rand);
    in_valid = 1'b1;
    in_data  = d;
    in_step  = st;
    do tick(req, rdy_rand); while (!acc_flag);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) tick(req, 1'b0);
    check(exp_q.size() == 0, {req, " rate"}, exp_q.size(), 0);
  endtask

  // Send whole groups of a fixed select; data mode 0 random, 1 full scale, 2 zero.
  task automatic groups(input logic [2:0] sel, input int ngrp, input int mode,
                        input string req, input bit rdy_rand);
    avg_sel = sel;
    for (int g = 0; g < ngrp; g++) begin
      logic [2:0] st;
      st = 3'($urandom);
      for (int k = 0; k < (1 << sat_sel(sel)); k++) begin
        logic [9:0] d;
        d = (mode == 1) ? 10'h3FF : (mode == 2) ? 10'h000 : 10'($urandom);
        send(d, (k == (1 << sat_sel(sel)) - 1) ? st : 3'($urandom), req, rdy_rand);
      end
    end
    drain(req);
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    #5;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset", int'({out_valid, in_ready}), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", int'({out_valid, in_ready}), 1);

    groups(3'd0, 40, 0, "R2 R7 bypass", 1'b0);
    groups(3'd0, 40, 0, "R2 R6 bypass stalled", 1'b1);
    for (int f = 1; f <= 6; f++) groups(3'(f), 6, 0, "R3 R7 average", 1'b0);
    groups(3'd2, 10, 2, "R3 zero", 1'b0);
    groups(3'd7, 3, 0, "R4 saturate", 1'b0);
    groups(3'd7, 1, 1, "R8 full scale", 1'b0);
    groups(3'd6, 1, 1, "R8 full scale 64", 1'b1);

    // R5: change the select randomly on every sample, even mid-group.
    for (int i = 0; i < 600; i++) begin
      avg_sel = 3'($urandom % 5);
      send(10'($urandom), 3'($urandom), "R5 select change", 1'b1);
    end
    avg_sel = 3'd0;
    while (m_cnt != 0) send(10'($urandom), 3'd5, "R5 finish", 1'b0);
    drain("R5");

    // Mixed random run with back-pressure.
    for (int i = 0; i < 20; i++)
      groups(3'($urandom), 2, 0, "R3 R6 mixed", 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule